// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block is the control and status core of a display controller. It accepts a stream of 16-bit words over a valid/ready handshake and, according to a load-mode field in its control register, treats that stream as a colour palette, as frame pixels, or as a palette followed by frames. Palette entries are written into an internal 256 x 12-bit colour table. The top nibble of the first palette word is a pixel-depth code that sets how many entries follow. Frame words are passed on to the pixel path one cycle after they are accepted. Frames repeat for as long as the controller stays enabled.

Turning the controller off is a handshake. When software clears the enable bit, the frame in progress still runs to its last word. Only then does the block go idle and raise a done flag. Alongside this, a status register collects the done, palette-loaded, vertical-sync, line, AC-bias, underflow and sync-lost flags. Each flag has its own clearing rule. An interrupt line combines the flags with a per-flag mask.

Top module: `lcd_load_seq`

## Requirements
- R1: A rising write of control bit 0 (enable) starts a load from idle. The mode is taken from control bits 21:20 of that write: 0 loads a palette and then frames, 1 loads a palette only, and 2 or 3 loads frames only. The mask sits in control bits 14:8. Control readback shows the enable bit, the mode and the mask at those positions, with zeros elsewhere.
- R2: Bits 15:12 of the first palette word are captured on `fmt_code_o`. Code 3 (8 bits per pixel) gives a palette of 256 words. Every other code gives 16 words.
- R3: Palette word n writes its bits 11:8 (red), 7:4 (green) and 3:0 (blue) as a 12-bit value into table entry n. `pal_rdata_o` shows entry `pal_raddr_i` in the same cycle. The table is all zeros after reset.
- R4: `s_ready_o` is high only while a palette or frame is loading. Each accepted frame word appears on `pix_data_o` with `pix_valid_o` high in the following cycle.
- R5: A frame holds FRAME_WORDS words. If enable is low when a frame's last word is accepted, the block goes idle. Otherwise the next frame begins. If enable is low while loading a palette or while holding after a palette-only load, the block goes idle in the next cycle. Going idle this way sets status bit 0 (done) only if mask bit 0 is set.
- R6: A status write never clears done. Done clears only when the enable bit is raised again.
- R7: Status bits 5 (underflow) and 6 (sync lost) are set by their event inputs while the block is active. They are cleared only by a control write that drops the enable bit.
- R8: Status bit 1 (palette loaded) is set when the last palette word is accepted with enable high. In palette-only mode, a status write with bit 1 set clears it. In the other modes it is cleared only when the enable bit drops.
- R9: Status bits 2 (vsync), 3 (line) and 4 (AC bias) are set by their event inputs while active and cleared by writing 1 to them. A set in the same cycle wins over a clear. All events are ignored while idle.
- R10: `irq_o` is high exactly when some status bit and its mask bit are both set.
- R11: After reset the control register, status, interrupt, ready and pixel outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data: enable bit 0, mask 14:8, mode 21:20 |
| ctrl_o | output | 32 | Control register readback |
| stat_we_i | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata_i | input | 7 | Status write data |
| stat_o | output | 7 | Status flags |
| irq_o | output | 1 | Masked interrupt request |
| ev_vsync_i | input | 1 | Vertical sync event pulse |
| ev_line_i | input | 1 | Line interrupt event pulse |
| ev_acb_i | input | 1 | AC-bias count event pulse |
| ev_underflow_i | input | 1 | Pixel FIFO underflow event pulse |
| ev_sync_lost_i | input | 1 | Sync lost event pulse |
| s_valid_i | input | 1 | Input word valid |
| s_ready_o | output | 1 | Input word accepted when high with valid |
| s_data_i | input | 16 | Input word |
| pix_valid_o | output | 1 | Frame word valid on pixel path |
| pix_data_o | output | 16 | Frame word |
| fmt_code_o | output | 4 | Pixel-depth code from the palette header |
| active_o | output | 1 | Block is loading or holding (not idle) |
| pal_raddr_i | input | 8 | Colour table read address |
| pal_rdata_o | output | 12 | Colour table read data |

## Verification
A wrong sequencer state shows up at once on `s_ready_o` and `active_o`, in the next cycle that word traffic arrives. A wrong word counter shows up one frame or one palette later, as a late or early return to idle or a misplaced palette-loaded flag. A wrong clearing rule shows up in the cycle after the control or status write that should, or should not, clear a flag, and from then on it also corrupts `irq_o`. A corrupted colour table entry is visible the moment the bench sweeps its address.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAL   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FRAME = 2'd3
  } seq_state_e;

  localparam int STAT_W  = 7;
  localparam int S_DONE  = 0;
  localparam int S_PAL   = 1;
  localparam int S_VSYNC = 2;
  localparam int S_LINE  = 3;
  localparam int S_ACB   = 4;
  localparam int S_UFLOW = 5;
  localparam int S_SLOST = 6;

  localparam logic [1:0] MODE_PAL_FRAME = 2'd0;
  localparam logic [1:0] MODE_PAL_ONLY  = 2'd1;
  localparam logic [3:0] CODE_8BPP      = 4'h3;
endpackage

// File: rtl/lcd_pal_ram.sv
module lcd_pal_ram #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_WORDS = 76800,
  parameter int SHORT_PAL   = 16,
  parameter int PAL_AW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        start_mode_i,
  input  logic [1:0]        mode_i,
  input  logic              en_i,
  input  logic              s_valid_i,
  input  logic [15:0]       s_data_i,
  output logic              s_ready_o,
  output logic              pal_we_o,
  output logic [PAL_AW-1:0] pal_waddr_o,
  output logic [11:0]       pal_wdata_o,
  output logic [3:0]        code_o,
  output logic              pal_done_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              pix_valid_o,
  output logic [15:0]       pix_data_o
);
  localparam int FW = (FRAME_WORDS > 2) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [FW-1:0]     FRM_LAST  = FW'(FRAME_WORDS - 1);
  localparam logic [PAL_AW-1:0] LAST_LONG = '1;
  localparam logic [PAL_AW-1:0] LAST_SHRT = PAL_AW'(SHORT_PAL - 1);

  seq_state_e        state_q, state_d;
  logic [PAL_AW-1:0] pal_cnt_q, pal_last_q;
  logic [FW-1:0]     frm_cnt_q;
  logic [3:0]        code_q;
  logic              pix_valid_q;
  logic [15:0]       pix_data_q;
  logic              accept, pal_end, frm_acc, frm_end;

  assign s_ready_o   = (state_q == ST_PAL) || (state_q == ST_FRAME);
  assign accept      = s_valid_i && s_ready_o;
  assign pal_we_o    = accept && (state_q == ST_PAL);
  assign pal_waddr_o = pal_cnt_q;
  assign pal_wdata_o = s_data_i[11:0];
  assign pal_end     = pal_we_o && (pal_cnt_q != '0) && (pal_cnt_q == pal_last_q);
  assign frm_acc     = accept && (state_q == ST_FRAME);
  assign frm_end     = frm_acc && (frm_cnt_q == FRM_LAST);
  assign pal_done_o  = pal_end && en_i;
  assign busy_o      = state_q != ST_IDLE;
  assign code_o      = code_q;
  assign pix_valid_o = pix_valid_q;
  assign pix_data_o  = pix_data_q;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i)
        state_d = (start_mode_i == MODE_PAL_FRAME || start_mode_i == MODE_PAL_ONLY)
                  ? ST_PAL : ST_FRAME;
      ST_PAL: begin
        if (!en_i) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end else if (pal_end) begin
          state_d = (mode_i == MODE_PAL_ONLY) ? ST_HOLD : ST_FRAME;
        end
      end
      ST_HOLD: if (!en_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      ST_FRAME: if (frm_end && !en_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pal_cnt_q   <= '0;
      pal_last_q  <= LAST_SHRT;
      frm_cnt_q   <= '0;
      code_q      <= '0;
      pix_valid_q <= 1'b0;
      pix_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      pix_valid_q <= frm_acc;
      if (frm_acc) pix_data_q <= s_data_i;
      if (state_q == ST_IDLE && start_i) begin
        pal_cnt_q <= '0;
        frm_cnt_q <= '0;
      end
      if (pal_we_o) begin
        pal_cnt_q <= pal_end ? '0 : pal_cnt_q + 1'b1;
        if (pal_cnt_q == '0) begin
          code_q     <= s_data_i[15:12];
          pal_last_q <= (s_data_i[15:12] == CODE_8BPP) ? LAST_LONG : LAST_SHRT;
        end
      end
      if (frm_acc) frm_cnt_q <= frm_end ? '0 : frm_cnt_q + 1'b1;
    end
  end

  // R2: the word index never passes the length chosen by the header
  a_r2_pal_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAL && pal_cnt_q != '0) |-> (pal_cnt_q <= pal_last_q));
  // R5: a frame-path exit to idle only happens on a frame's last word
  a_r5_exit_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && state_d == ST_IDLE) |-> (frm_cnt_q == FRM_LAST && accept));
endmodule

// File: rtl/lcd_stat_reg.sv
module lcd_stat_reg
  import lcd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              ev_vsync_i,
  input  logic              ev_line_i,
  input  logic              ev_acb_i,
  input  logic              ev_underflow_i,
  input  logic              ev_sync_lost_i,
  input  logic              busy_i,
  input  logic              pal_done_i,
  input  logic              done_i,
  input  logic              dis_i,
  input  logic              en_rise_i,
  input  logic              pal_only_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic unused_clr;

  assign unused_clr = ^{clr_i[S_DONE], clr_i[S_UFLOW], clr_i[S_SLOST]};

  always_comb begin
    stat_d = stat_q;
    if (clr_we_i) begin
      if (clr_i[S_VSYNC]) stat_d[S_VSYNC] = 1'b0;
      if (clr_i[S_LINE])  stat_d[S_LINE]  = 1'b0;
      if (clr_i[S_ACB])   stat_d[S_ACB]   = 1'b0;
      if (clr_i[S_PAL] && pal_only_i) stat_d[S_PAL] = 1'b0;
    end
    if (busy_i) begin
      if (ev_vsync_i)     stat_d[S_VSYNC] = 1'b1;
      if (ev_line_i)      stat_d[S_LINE]  = 1'b1;
      if (ev_acb_i)       stat_d[S_ACB]   = 1'b1;
      if (ev_underflow_i) stat_d[S_UFLOW] = 1'b1;
      if (ev_sync_lost_i) stat_d[S_SLOST] = 1'b1;
    end
    if (pal_done_i) stat_d[S_PAL] = 1'b1;
    if (done_i && mask_i[S_DONE]) stat_d[S_DONE] = 1'b1;
    if (dis_i) begin
      stat_d[S_UFLOW] = 1'b0;
      stat_d[S_SLOST] = 1'b0;
      if (!pal_only_i) stat_d[S_PAL] = 1'b0;
    end
    if (en_rise_i) stat_d[S_DONE] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[S_DONE] && !en_rise_i) |=> stat_q[S_DONE]);
  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[S_UFLOW] && !dis_i) |=> stat_q[S_UFLOW]);
  a_r9_vsync_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_i[S_VSYNC] && !(busy_i && ev_vsync_i)) |=> !stat_q[S_VSYNC]);
endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_WORDS = 76800,
  parameter int SHORT_PAL   = 16,
  parameter int PAL_AW      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_o,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o,
  input  logic              ev_vsync_i,
  input  logic              ev_line_i,
  input  logic              ev_acb_i,
  input  logic              ev_underflow_i,
  input  logic              ev_sync_lost_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [15:0]       s_data_i,
  output logic              pix_valid_o,
  output logic [15:0]       pix_data_o,
  output logic [3:0]        fmt_code_o,
  output logic              active_o,
  input  logic [PAL_AW-1:0] pal_raddr_i,
  output logic [11:0]       pal_rdata_o
);
  logic              en_q;
  logic [1:0]        mode_q;
  logic [STAT_W-1:0] mask_q;
  logic              en_rise, dis, busy, done_p, pal_done, pal_we;
  logic [PAL_AW-1:0] pal_waddr;
  logic [11:0]       pal_wdata;
  logic unused_ctrl;

  assign unused_ctrl = ^{ctrl_wdata_i[31:22], ctrl_wdata_i[19:15], ctrl_wdata_i[7:1]};
  assign en_rise = ctrl_we_i && ctrl_wdata_i[0] && !en_q;
  assign dis     = ctrl_we_i && !ctrl_wdata_i[0] && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      mask_q <= '0;
    end else if (ctrl_we_i) begin
      en_q   <= ctrl_wdata_i[0];
      mode_q <= ctrl_wdata_i[21:20];
      mask_q <= ctrl_wdata_i[8 +: STAT_W];
    end
  end

  assign ctrl_o   = {10'b0, mode_q, 5'b0, mask_q, 7'b0, en_q};
  assign active_o = busy;

  lcd_seq_fsm #(
    .FRAME_WORDS (FRAME_WORDS),
    .SHORT_PAL   (SHORT_PAL),
    .PAL_AW      (PAL_AW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (en_rise),
    .start_mode_i (ctrl_wdata_i[21:20]),
    .mode_i       (mode_q),
    .en_i         (en_q),
    .s_valid_i    (s_valid_i),
    .s_data_i     (s_data_i),
    .s_ready_o    (s_ready_o),
    .pal_we_o     (pal_we),
    .pal_waddr_o  (pal_waddr),
    .pal_wdata_o  (pal_wdata),
    .code_o       (fmt_code_o),
    .pal_done_o   (pal_done),
    .done_o       (done_p),
    .busy_o       (busy),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o)
  );

  lcd_pal_ram #(
    .AW (PAL_AW),
    .DW (12)
  ) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we),
    .waddr_i (pal_waddr),
    .wdata_i (pal_wdata),
    .raddr_i (pal_raddr_i),
    .rdata_o (pal_rdata_o)
  );

  lcd_stat_reg u_stat (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clr_we_i       (stat_we_i),
    .clr_i          (stat_wdata_i),
    .ev_vsync_i     (ev_vsync_i),
    .ev_line_i      (ev_line_i),
    .ev_acb_i       (ev_acb_i),
    .ev_underflow_i (ev_underflow_i),
    .ev_sync_lost_i (ev_sync_lost_i),
    .busy_i         (busy),
    .pal_done_i     (pal_done),
    .done_i         (done_p),
    .dis_i          (dis),
    .en_rise_i      (en_rise),
    .pal_only_i     (mode_q == MODE_PAL_ONLY),
    .mask_i         (mask_q),
    .stat_o         (stat_o),
    .irq_o          (irq_o)
  );

  a_r4_pix_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(s_valid_i && s_ready_o));
  a_r5_done_rises_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[S_DONE]) |-> !busy);
  a_r4_ready_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> active_o);
endmodule

// File: tb/lcd_load_seq_test.sv
module lcd_load_seq_test;
  localparam int CLK_P = 10;
  localparam int FRM   = 12;

  logic        clk = 0, rst_n = 0;
  logic        ctrl_we = 0, stat_we = 0, s_valid = 0;
  logic [31:0] ctrl_wd = 0;
  logic [6:0]  stat_wd = 0;
  logic [4:0]  ev = 0;
  logic [15:0] s_data = 0;
  logic [7:0]  raddr = 0;
  logic [31:0] ctrl_o;
  logic [6:0]  stat_o;
  logic        irq_o, s_ready_o, pix_valid_o, active_o;
  logic [15:0] pix_data_o;
  logic [3:0]  fmt_code_o;
  logic [11:0] pal_rdata_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_load_seq #(.FRAME_WORDS(FRM), .SHORT_PAL(16), .PAL_AW(8)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_o(ctrl_o),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wd), .stat_o(stat_o), .irq_o(irq_o),
    .ev_vsync_i(ev[0]), .ev_line_i(ev[1]), .ev_acb_i(ev[2]),
    .ev_underflow_i(ev[3]), .ev_sync_lost_i(ev[4]),
    .s_valid_i(s_valid), .s_ready_o(s_ready_o), .s_data_i(s_data),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o),
    .fmt_code_o(fmt_code_o), .active_o(active_o),
    .pal_raddr_i(raddr), .pal_rdata_o(pal_rdata_o)
  );

  // reference model: 0 idle, 1 palette, 2 hold, 3 frame
  int   ms, mpc, mfc, mlim;
  bit   m_en, m_pv;
  int   m_mode, m_code, m_pd;
  bit [6:0] m_mask, m_stat;
  int   m_pal [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mpc = 0; mfc = 0; mlim = 15; m_en = 0; m_pv = 0;
      m_mode = 0; m_code = 0; m_pd = 0; m_mask = 0; m_stat = 0;
      for (int i = 0; i < 256; i++) m_pal[i] = 0;
    end else begin
      bit rdy, acc, rise, fall, dset, pset, busy, last, pal_only;
      int ns;
      rdy  = (ms == 1 || ms == 3);
      acc  = s_valid && rdy;
      rise = ctrl_we && ctrl_wd[0] && !m_en;
      fall = ctrl_we && !ctrl_wd[0] && m_en;
      busy = ms != 0;
      pal_only = (m_mode == 1);
      dset = 0; pset = 0; ns = ms; m_pv = 0;
      case (ms)
        0: if (rise) begin
             ns = (ctrl_wd[21:20] <= 1) ? 1 : 3; mpc = 0; mfc = 0;
           end
        1: begin
             last = 0;
             if (acc) begin
               m_pal[mpc] = int'(s_data[11:0]);
               last = (mpc != 0) && (mpc == mlim);
               if (mpc == 0) begin
                 m_code = int'(s_data[15:12]);
                 mlim = (s_data[15:12] == 4'h3) ? 255 : 15;
               end
               mpc = last ? 0 : mpc + 1;
             end
             if (!m_en) begin ns = 0; dset = 1; end
             else if (last) begin pset = 1; ns = pal_only ? 2 : 3; end
           end
        2: if (!m_en) begin ns = 0; dset = 1; end
        default: if (acc) begin
             m_pv = 1; m_pd = int'(s_data);
             last = (mfc == FRM - 1);
             mfc = last ? 0 : mfc + 1;
             if (last && !m_en) begin ns = 0; dset = 1; end
           end
      endcase
      if (stat_we) begin
        for (int b = 2; b <= 4; b++) if (stat_wd[b]) m_stat[b] = 0;
        if (stat_wd[1] && pal_only) m_stat[1] = 0;
      end
      if (busy) for (int b = 0; b < 5; b++) if (ev[b]) m_stat[b+2] = 1;
      if (pset) m_stat[1] = 1;
      if (dset && m_mask[0]) m_stat[0] = 1;
      if (fall) begin m_stat[5] = 0; m_stat[6] = 0; if (!pal_only) m_stat[1] = 0; end
      if (rise) m_stat[0] = 0;
      if (ctrl_we) begin
        m_en = ctrl_wd[0]; m_mode = int'(ctrl_wd[21:20]); m_mask = ctrl_wd[14:8];
      end
      ms = ns;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #(CLK_P/4);
      chk("R4 ready", 32'(s_ready_o), 32'(ms == 1 || ms == 3));
      chk("R5 active", 32'(active_o), 32'(ms != 0));
      chk("R1 ctrl readback", ctrl_o,
          {10'b0, 2'(m_mode), 5'b0, m_mask, 7'b0, m_en});
      chk("R2 format code", 32'(fmt_code_o), 32'(m_code));
      chk("R3 palette read", 32'(pal_rdata_o), 32'(m_pal[raddr]));
      chk("R6 done bit", 32'(stat_o[0]), 32'(m_stat[0]));
      chk("R8 palette loaded bit", 32'(stat_o[1]), 32'(m_stat[1]));
      chk("R9 vsync/line/acb bits", 32'(stat_o[4:2]), 32'(m_stat[4:2]));
      chk("R7 underflow/sync-lost bits", 32'(stat_o[6:5]), 32'(m_stat[6:5]));
      chk("R10 irq", 32'(irq_o), 32'(|(m_stat & m_mask)));
      chk("R4 pixel valid", 32'(pix_valid_o), 32'(m_pv));
      if (m_pv) chk("R4 pixel data", 32'(pix_data_o), 32'(m_pd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_ctrl(logic [31:0] v);
    ctrl_we = 1; ctrl_wd = v; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_stat(logic [6:0] v);
    stat_we = 1; stat_wd = v; @(negedge clk); stat_we = 0;
  endtask
  task automatic pulse(logic [4:0] v);
    ev = v; @(negedge clk); ev = 0;
  endtask
  task automatic push(logic [15:0] w);
    logic rdy;
    s_valid = 1; s_data = w;
    for (int k = 0; k < 50; k++) begin
      rdy = s_ready_o;
      @(negedge clk);
      if (rdy) break;
    end
    s_valid = 0;
  endtask
  task automatic send_pal(logic [3:0] code, int n);
    for (int i = 0; i < n; i++)
      push({(i == 0) ? code : 4'(i), 12'((i * 37 + 5) & 12'hFFF)});
  endtask
  task automatic drain();
    for (int k = 0; k < 100 && active_o; k++) push(16'(16'hA000 + k));
  endtask
  task automatic sweep(int n);
    for (int i = 0; i < n; i++) begin raddr = 8'(i); @(negedge clk); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 ctrl reset", ctrl_o, 0);
    chk("R11 status reset", 32'(stat_o), 0);
    chk("R11 irq/ready/pix reset", 32'({irq_o, s_ready_o, pix_valid_o}), 0);
    // R1 mode 0: palette (code 4, 16 words) then frames
    wr_ctrl(32'h0000_7F01);
    send_pal(4'h4, 16);
    chk("R2 short palette code", 32'(fmt_code_o), 32'h4);
    chk("R8 loaded after palette", 32'(stat_o[1]), 1);
    for (int i = 0; i < 5; i++) push(16'(16'h5000 + i));
    pulse(5'b11111);
    wr_stat(7'h7F);           // R6 R7 R8: only vsync/line/acb clear here
    chk("R7 underflow survives status write", 32'(stat_o[5]), 1);
    chk("R8 loaded survives status write in mode 0", 32'(stat_o[1]), 1);
    push(16'h5005);
    wr_ctrl(32'h0000_7F00);   // R5: disable mid frame
    chk("R5 still active after disable", 32'(active_o), 1);
    chk("R7 errors cleared by disable", 32'(stat_o[6:5]), 0);
    drain();
    chk("R5 done after frame end", 32'(stat_o[0]), 1);
    chk("R10 irq from done", 32'(irq_o), 1);
    wr_stat(7'h01);
    chk("R6 done not write-clearable", 32'(stat_o[0]), 1);
    sweep(20);
    // R1 mode 2 frame only, done masked
    wr_ctrl(32'h0020_7E01);
    chk("R6 done cleared on enable", 32'(stat_o[0]), 0);
    for (int i = 0; i < 2 * FRM; i++) push(16'(16'h6000 + i));
    wr_ctrl(32'h0020_7E00);
    drain();
    chk("R5 masked done stays low", 32'(stat_o[0]), 0);
    // R1 mode 1 palette only, 8bpp header -> 256 words
    wr_ctrl(32'h0010_7F01);
    send_pal(4'h3, 256);
    chk("R2 long palette", 32'(active_o && !s_ready_o), 1);
    pulse(5'b00001);
    wr_stat(7'h02);
    chk("R8 loaded write-cleared in palette-only", 32'(stat_o[1]), 0);
    wr_ctrl(32'h0010_7F00);
    @(negedge clk);
    chk("R5 hold exits to done", 32'({active_o, stat_o[0]}), 32'b01);
    sweep(256);
    // R9: events while idle ignored
    wr_stat(7'h1C);
    pulse(5'b11111);
    chk("R9 events ignored while idle", 32'(stat_o[6:2]), 0);
    // R5: disable during a palette load, code 0
    wr_ctrl(32'h0010_7F01);
    send_pal(4'h0, 5);
    wr_ctrl(32'h0010_7F00);
    @(negedge clk);
    chk("R5 palette abort to idle", 32'({active_o, stat_o[0]}), 32'b01);
    chk("R2 code 0 captured", 32'(fmt_code_o), 0);
    sweep(8);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule